// File: doc/BRIEF.md
# Two-Phase Scan Chain Host Controller

This block sits on the tester side of a latch-based serial scan chain and drives that chain through five pins. The pins are two pulsed, non-overlapping shift phases (`phiOut` and `phiBarOut`), a serial data line, a capture-select line and a commit line. The chain's last bit comes back on `serialIn`. A host gives the block a command, a parallel image as wide as the whole chain, and a programmable pulse length, then strobes `startReq`.

The controller then runs the pulse sequence for that command:

- It can capture chip-side values into the chain.
- It shifts the image in least-significant bit first, one phase pair per bit. While it does so it collects the bits that fall out of the chain.
- It can pulse the commit line so that the chip-side latches take the new contents.

When the sequence is over, `done` rises for one cycle and `readImage` holds the collected image.

Every pulse, and every gap between pin transitions, lasts the programmed number of system clocks, with a floor of one clock. This gives data setup before each phase and a clean separation between the two phases.

Top module: `scan_host`

## Requirements
- R1: After reset, and whenever `busy` is low, `phiOut`, `phiBarOut`, `serialOut`, `captureSel` and `commitOut` are all low. `busy` and `done` are also low after reset.
- R2: `phiOut` and `phiBarOut` are never high in the same cycle. Every pulse on `phiOut`, `phiBarOut` or `commitOut` lasts exactly max(`pulseCycles`,1) clocks, where `pulseCycles` is sampled when the command is accepted.
- R3: A rotation produces exactly CHAIN_LEN pulses on `phiOut` and CHAIN_LEN pulses on `phiBarOut`. The two alternate, starting with `phiOut`.
- R4: During bit k of a rotation, `serialOut` carries bit k of `writeImage` (least significant bit first). The value is set before `phiOut` rises and held unchanged through both pulses of that bit.
- R5: Before each bit's `phiOut` pulse, `serialIn` is sampled and shifted in at the top of the capture image. After the rotation, bit k of `readImage` therefore equals bit k of the chain contents as they stood before the rotation.
- R6: Command 2'b01 (write) performs a rotation followed by exactly one `commitOut` pulse, with no `captureSel` activity.
- R7: Command 2'b10 (read) performs the capture sequence, then a rotation, with no `commitOut` pulse. In the capture sequence, `captureSel` rises while both phases are low, one `phiOut` pulse and one `phiBarOut` pulse follow, and `captureSel` falls while both phases are low. `readImage` then equals the chip-side values.
- R8: Command 2'b11 (combined) performs the capture sequence, the rotation and one commit pulse, in that order. It returns the chip-side values and commits the new image.
- R9: `commitOut` is high only while `phiOut`, `phiBarOut` and `captureSel` are all low.
- R10: A start with command 2'b00, or a start while `busy` is high, is ignored. `done` is high for exactly one cycle per accepted command, and `busy` is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start strobe, sampled while idle |
| cmdSel | input | 2 | Command: 01 write, 10 read, 11 combined, 00 none |
| writeImage | input | CHAIN_LEN | Image to shift into the chain, bit 0 first |
| pulseCycles | input | CNT_W | Clocks per pulse and per gap (0 acts as 1) |
| serialIn | input | 1 | Serial output of the chain |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion flag |
| readImage | output | CHAIN_LEN | Image collected during the rotation |
| phiOut | output | 1 | First shift phase pulse |
| phiBarOut | output | 1 | Second shift phase pulse |
| serialOut | output | 1 | Serial data into the chain |
| captureSel | output | 1 | Selects chip-side values as chain input |
| commitOut | output | 1 | Commits chain contents to the chip side |

## Verification
The bench attaches a behavioural model of the external two-latch chain. The model has a capture multiplexer and commit latches, with chip-side read values in the upper half of the chain and the committed latches read back in the lower half.

Two asymmetric write images are rotated back to back, so that the second readback exposes bit order and any off-by-one shift. Read and combined commands are then given distinct chip-side values, which separates data that was captured from data that was rotated around. A combined command also shows whether the commit lands after the rotation.

Pulse lengths of 0, 1, 2 and 3 check the width floor and the width counter. A command 00 start and a start issued during a run check that unwanted starts are ignored.

// File: rtl/scan_host_pkg.sv
package scan_host_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_BOTH  = 2'b11
  } scan_cmd_e;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic loadImage;
    logic sampleBit;
    logic shiftBit;
    logic driveData;
  } dp_strobe_t;

endpackage

// File: rtl/scan_host_dp.sv
module scan_host_dp
  import scan_host_pkg::*;
#(
  parameter int CHAIN_LEN = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dp_strobe_t           strobes,
  input  logic [CHAIN_LEN-1:0] writeImage,
  input  logic                 serialIn,
  output logic                 serialOut,
  output logic [CHAIN_LEN-1:0] readImage
);

  logic [CHAIN_LEN-1:0] shiftReg;
  logic [CHAIN_LEN-1:0] capReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      capReg   <= '0;
    end else if (strobes.loadImage) begin
      shiftReg <= writeImage;
      capReg   <= '0;
    end else begin
      if (strobes.sampleBit) capReg   <= {serialIn, capReg[CHAIN_LEN-1:1]};
      if (strobes.shiftBit)  shiftReg <= {1'b0, shiftReg[CHAIN_LEN-1:1]};
    end
  end

  assign serialOut = strobes.driveData & shiftReg[0];
  assign readImage = capReg;

endmodule

// File: rtl/scan_host_ctrl.sv
module scan_host_ctrl
  import scan_host_pkg::*;
#(
  parameter int CHAIN_LEN = 12,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [1:0]       cmdSel,
  input  logic [CNT_W-1:0] pulseCycles,
  output dp_strobe_t       strobes,
  output logic             phiOut,
  output logic             phiBarOut,
  output logic             captureSel,
  output logic             commitOut,
  output logic             busy,
  output logic             done
);

  localparam int BIT_W = $clog2(CHAIN_LEN + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAIN_LEN - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CAP_SETUP, ST_CAP_PHI_H, ST_CAP_PHI_L, ST_CAP_PHB_H, ST_CAP_PHB_L,
    ST_ROT_SETUP, ST_ROT_PHI_H, ST_ROT_PHI_L, ST_ROT_PHB_H, ST_ROT_PHB_L,
    ST_COM_H, ST_COM_L, ST_FINISH
  } state_e;

  state_e           state, nextState;
  logic [CNT_W-1:0] timer, tLen;
  logic [BIT_W-1:0] bitCnt;
  logic             doCommit;
  logic             accept, stepEnd, timed;

  assign accept  = (state == ST_IDLE) && startReq && (cmdSel != CMD_NONE);
  assign timed   = (state != ST_IDLE) && (state != ST_FINISH);
  assign stepEnd = (timer == tLen - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      timer    <= '0;
      tLen     <= CNT_W'(1);
      bitCnt   <= '0;
      doCommit <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) begin
        tLen     <= (pulseCycles == '0) ? CNT_W'(1) : pulseCycles;
        doCommit <= cmdSel[0];
        bitCnt   <= '0;
        timer    <= '0;
      end else if (timed) begin
        timer <= stepEnd ? '0 : timer + CNT_W'(1);
      end
      if (state == ST_ROT_PHB_L && stepEnd) bitCnt <= bitCnt + BIT_W'(1);
    end
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:      if (accept) nextState = cmdSel[1] ? ST_CAP_SETUP : ST_ROT_SETUP;
      ST_CAP_SETUP: if (stepEnd) nextState = ST_CAP_PHI_H;
      ST_CAP_PHI_H: if (stepEnd) nextState = ST_CAP_PHI_L;
      ST_CAP_PHI_L: if (stepEnd) nextState = ST_CAP_PHB_H;
      ST_CAP_PHB_H: if (stepEnd) nextState = ST_CAP_PHB_L;
      ST_CAP_PHB_L: if (stepEnd) nextState = ST_ROT_SETUP;
      ST_ROT_SETUP: if (stepEnd) nextState = ST_ROT_PHI_H;
      ST_ROT_PHI_H: if (stepEnd) nextState = ST_ROT_PHI_L;
      ST_ROT_PHI_L: if (stepEnd) nextState = ST_ROT_PHB_H;
      ST_ROT_PHB_H: if (stepEnd) nextState = ST_ROT_PHB_L;
      ST_ROT_PHB_L:
        if (stepEnd) begin
          if (bitCnt == LAST_BIT) nextState = doCommit ? ST_COM_H : ST_FINISH;
          else                    nextState = ST_ROT_SETUP;
        end
      ST_COM_H:     if (stepEnd) nextState = ST_COM_L;
      ST_COM_L:     if (stepEnd) nextState = ST_FINISH;
      ST_FINISH:    nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  assign phiOut     = (state == ST_CAP_PHI_H) || (state == ST_ROT_PHI_H);
  assign phiBarOut  = (state == ST_CAP_PHB_H) || (state == ST_ROT_PHB_H);
  assign captureSel = (state == ST_CAP_SETUP) || (state == ST_CAP_PHI_H) ||
                      (state == ST_CAP_PHI_L) || (state == ST_CAP_PHB_H) ||
                      (state == ST_CAP_PHB_L);
  assign commitOut  = (state == ST_COM_H);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FINISH);

  assign strobes.loadImage = accept;
  assign strobes.sampleBit = (state == ST_ROT_SETUP) && stepEnd;
  assign strobes.shiftBit  = (state == ST_ROT_PHB_L) && stepEnd;
  assign strobes.driveData = (state == ST_ROT_SETUP) || (state == ST_ROT_PHI_H) ||
                             (state == ST_ROT_PHI_L) || (state == ST_ROT_PHB_H) ||
                             (state == ST_ROT_PHB_L);

endmodule

// File: rtl/scan_host.sv
module scan_host
  import scan_host_pkg::*;
#(
  parameter int CHAIN_LEN = 12,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 startReq,
  input  logic [1:0]           cmdSel,
  input  logic [CHAIN_LEN-1:0] writeImage,
  input  logic [CNT_W-1:0]     pulseCycles,
  input  logic                 serialIn,
  output logic                 busy,
  output logic                 done,
  output logic [CHAIN_LEN-1:0] readImage,
  output logic                 phiOut,
  output logic                 phiBarOut,
  output logic                 serialOut,
  output logic                 captureSel,
  output logic                 commitOut
);

  dp_strobe_t strobes;

  scan_host_ctrl #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startReq   (startReq),
    .cmdSel     (cmdSel),
    .pulseCycles(pulseCycles),
    .strobes    (strobes),
    .phiOut     (phiOut),
    .phiBarOut  (phiBarOut),
    .captureSel (captureSel),
    .commitOut  (commitOut),
    .busy       (busy),
    .done       (done)
  );

  scan_host_dp #(.CHAIN_LEN(CHAIN_LEN)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .writeImage(writeImage),
    .serialIn  (serialIn),
    .serialOut (serialOut),
    .readImage (readImage)
  );

endmodule

// File: rtl/scan_host_chk.sv
module scan_host_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic phiOut,
  input logic phiBarOut,
  input logic serialOut,
  input logic captureSel,
  input logic commitOut
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(phiOut || phiBarOut || serialOut || captureSel || commitOut));

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(phiOut && phiBarOut));

  assert_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phiOut || phiBarOut) |-> $stable(serialOut));

  assert_sel_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(captureSel) |-> !phiOut && !phiBarOut);

  assert_sel_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(captureSel) |-> !phiOut && !phiBarOut);

  assert_commit_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commitOut |-> !phiOut && !phiBarOut && !captureSel);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

endmodule

bind scan_host scan_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .phiOut    (phiOut),
  .phiBarOut (phiBarOut),
  .serialOut (serialOut),
  .captureSel(captureSel),
  .commitOut (commitOut)
);

// File: tb/scan_host_test.sv
module scan_host_test;

  localparam int N  = 12;
  localparam int WR = 6;

  typedef struct packed {
    logic [N-1:0] img;
    logic [N-1:0] com;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         startReq = 1'b0;
  logic [1:0]   cmdSel = 2'b00;
  logic [N-1:0] writeImage = '0;
  logic [7:0]   pulseCycles = 8'd1;
  logic         serialIn;
  logic         busy, done, phiOut, phiBarOut, serialOut, captureSel, commitOut;
  logic [N-1:0] readImage;

  always #10 clk = ~clk;

  scan_host #(.CHAIN_LEN(N), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cmdSel(cmdSel),
    .writeImage(writeImage), .pulseCycles(pulseCycles), .serialIn(serialIn),
    .busy(busy), .done(done), .readImage(readImage), .phiOut(phiOut),
    .phiBarOut(phiBarOut), .serialOut(serialOut), .captureSel(captureSel),
    .commitOut(commitOut)
  );

  // behavioural external chain: master/slave latches, capture mux, commit latch
  logic [N-1:0]    chMaster = '0;
  logic [N-1:0]    chSlave = '0;
  logic [N-1:0]    chCommitted = '0;
  logic [N-WR-1:0] chipReadVals = '0;
  logic [N-1:0]    chipView;
  assign chipView = {chipReadVals, chCommitted[WR-1:0]};
  assign serialIn = chSlave[0];
  always @(posedge phiOut)    chMaster <= captureSel ? chipView : {serialOut, chSlave[N-1:1]};
  always @(posedge phiBarOut) chSlave <= chMaster;
  always @(posedge commitOut) chCommitted <= chSlave;

  // scoreboard
  exp_t expQ[$];
  int   checks = 0, failures = 0, monChecks = 0, monFails = 0;
  int   curT = 1;
  int   phiRise = 0, phbRise = 0, comRise = 0, capRise = 0;
  int   widthErr = 0, orderErr = 0, doneCnt = 0, run = 0;
  logic prevPhi = 0, prevPhb = 0, prevCom = 0, prevDone = 0, lastPhi = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (phiOut && !prevPhi) begin
      phiRise++;
      if (captureSel) capRise++;
      if (lastPhi) orderErr++;
      lastPhi = 1'b1;
    end
    if (phiBarOut && !prevPhb) begin
      phbRise++;
      if (!lastPhi) orderErr++;
      lastPhi = 1'b0;
    end
    if (commitOut && !prevCom) comRise++;
    if (phiOut || phiBarOut || commitOut) run++;
    else if (prevPhi || prevPhb || prevCom) begin
      if (run != curT) widthErr++;
      run = 0;
    end
    if (prevDone) begin
      monChecks++;
      if (done || busy) begin
        monFails++;
        $display("FAIL R10 done/busy after done actual=%0d%0d expected=00", done, busy);
      end
    end
    if (done) begin
      doneCnt++;
      monChecks++;
      if (expQ.size() == 0) begin
        monFails++;
        $display("FAIL R10 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        monChecks++;
        if (readImage !== e.img) begin
          monFails++;
          $display("FAIL R5 readImage actual=%0h expected=%0h", readImage, e.img);
        end
        if (chCommitted !== e.com) begin
          monFails++;
          $display("FAIL R4 committed chain actual=%0h expected=%0h", chCommitted, e.com);
        end
      end
    end
    prevPhi = phiOut; prevPhb = phiBarOut; prevCom = commitOut; prevDone = done;
  end

  // abstract expected state of the chain
  logic [N-1:0] modelChain = '0;
  logic [N-1:0] modelCommit = '0;

  task automatic runTxn(input logic [1:0] cmd, input logic [N-1:0] img,
                        input logic [7:0] pc, input bit intrude, input string req);
    int p0, b0, c0, k0, w0, o0, d0;
    exp_t e;
    logic [N-1:0] pre;
    pre = cmd[1] ? {chipReadVals, modelCommit[WR-1:0]} : modelChain;
    e.img = pre;
    modelChain = img;
    if (cmd[0]) modelCommit = img;
    e.com = modelCommit;
    expQ.push_back(e);
    @(posedge clk);
    curT = (pc == 0) ? 1 : int'(pc);
    p0 = phiRise; b0 = phbRise; c0 = comRise; k0 = capRise;
    w0 = widthErr; o0 = orderErr; d0 = doneCnt;
    @(negedge clk);
    startReq = 1'b1; cmdSel = cmd; writeImage = img; pulseCycles = pc;
    @(negedge clk);
    startReq = 1'b0;
    if (intrude) begin
      repeat (10) @(negedge clk);
      startReq = 1'b1; cmdSel = 2'b11; writeImage = ~img; pulseCycles = 8'd1;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (doneCnt == d0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(doneCnt - d0 == 1, {req, " R10 one done"}, doneCnt - d0, 1);
    chk(phiRise - p0 == N + (cmd[1] ? 1 : 0), {req, " R3 phi pulses"}, phiRise - p0, N + (cmd[1] ? 1 : 0));
    chk(phbRise - b0 == N + (cmd[1] ? 1 : 0), {req, " R3 phiBar pulses"}, phbRise - b0, N + (cmd[1] ? 1 : 0));
    chk(orderErr == o0, {req, " R3 alternation"}, orderErr - o0, 0);
    chk(widthErr == w0, {req, " R2 pulse width"}, widthErr - w0, 0);
    chk(comRise - c0 == (cmd[0] ? 1 : 0), {req, " commit pulses R6/R8"}, comRise - c0, cmd[0] ? 1 : 0);
    chk(capRise - k0 == (cmd[1] ? 1 : 0), {req, " R7 capture pulses"}, capRise - k0, cmd[1] ? 1 : 0);
    chk(!busy && !phiOut && !phiBarOut && !serialOut && !captureSel && !commitOut,
        {req, " R1 idle pins"}, {busy, phiOut, phiBarOut, serialOut, captureSel, commitOut}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + monChecks, failures + monFails);
    $finish;
  end

  initial begin : main
    int d0;
    bit moved;
    repeat (3) @(negedge clk);
    chk({busy, done, phiOut, phiBarOut, serialOut, captureSel, commitOut} == 0,
        "R1 reset outputs", {busy, done, phiOut, phiBarOut, serialOut, captureSel, commitOut}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: command 00 is ignored
    d0 = doneCnt; moved = 0;
    startReq = 1'b1; cmdSel = 2'b00; writeImage = 12'hFFF;
    @(negedge clk);
    startReq = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (busy || phiOut || captureSel || commitOut) moved = 1;
      @(negedge clk);
    end
    chk(!moved && doneCnt == d0, "R10 null command ignored", moved, 0);

    // R6 / R4 / R5: two writes, second reads back the first
    runTxn(2'b01, 12'hA5C, 8'd1, 0, "write1");
    runTxn(2'b01, 12'h3F0, 8'd3, 0, "write2");
    // R7: read with chip-side values
    chipReadVals = 6'b101101;
    runTxn(2'b10, 12'h0F3, 8'd2, 0, "read");
    // R8: combined, pulse length 0 acts as 1
    chipReadVals = 6'b010011;
    runTxn(2'b11, 12'h9B6, 8'd0, 0, "both");
    // R10: start during busy ignored
    runTxn(2'b01, 12'h5A3, 8'd2, 1, "intrude");
    chipReadVals = 6'b111000;
    runTxn(2'b11, 12'h001, 8'd1, 0, "both2");

    chk(expQ.size() == 0, "R10 scoreboard drained", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + monChecks, failures + monFails);
    $finish;
  end

endmodule